// File: doc/BRIEF.md
# Memory Request Target with Per-Function Regions

This block serves host memory accesses that arrive through a PCIe endpoint's transaction interface. Request packets come in on a 128-bit receive stream, four dwords per beat, with the last beat of each packet flagged. A write request stores its payload dwords into an on-chip RAM. A read request fetches dwords from that RAM and answers with one completion-with-data packet on a 128-bit transmit stream. The RAM is divided into equal regions, one for each physical function and each of its virtual functions. The function number carried in the request picks the region.

Only one request is handled at a time. While a completion is pending, the receive stream is held off. A halt input can also pause the receive side at any time. A completion may start only when the transmit credit counter is nonzero. Starting one uses a credit, and a pulse on the credit-return input gives one back. A request that cannot be served is dropped silently: its payload is still drained up to the end of the packet, and no completion is sent.

Top module: `mem_tlp_target`

## Requirements
- R1: A write request stores payload dword k (lane k mod 4 of payload beat k/4, lane j in bits [32j+31:32j]) at dword offset + k of the selected region, for k below the length. Dwords past the length are discarded.
- R2: A read request yields exactly one completion: one header beat followed by ceil(length/4) data beats, with tlast only on the final beat. Data dwords run in ascending address order from lane 0, and lanes past the length are zero.
- R3: The completion header holds the following dwords. dw0 = {8'h4A, 14'b0, length}. dw1 = {function id[15:0], 3'b000 success status, 1'b0, byte count = length*4 in 12 bits}. dw2 = {requester id, tag, 1'b0, address[6:0]}. dw3 = 0.
- R4: The request header is beat 0 and uses these fields. dw0 bit 30 is 1 for a write and 0 for a read, and dw0[9:0] is the length in dwords. dw1[31:16] is the requester id and dw1[7:0] is the tag. dw2[0] is the physical function, dw2[8] is the virtual-function flag, and dw2[20:16] is the virtual function index. dw3 is the byte address. The region index is pf*33 + (flag ? vf+1 : 0), so each region is separate from the others.
- R5: A request is dropped when any of these holds: the length is 0, address[1:0] is nonzero, offset+length exceeds the 16-dword region, or the function number is out of range. A dropped request writes nothing and sends no completion, and its beats are still taken up to tlast.
- R6: From the acceptance of a read's last beat until the final completion beat is accepted, the receive ready output stays low.
- R7: While the halt input is high, the receive ready output is low.
- R8: No completion header is sent while the credit count is zero. Each completion uses one credit, and each credit-return pulse adds one, up to 15. After reset there are 4 credits.
- R9: While transmit valid is high and transmit ready is low, valid, data and last hold steady.
- R10: After reset, receive ready is high (when not halted) and transmit valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 128 | Request beat, four dwords |
| rx_valid | input | 1 | Request beat valid |
| rx_last | input | 1 | Last beat of the request packet |
| rx_ready | output | 1 | Block accepts a request beat |
| rx_halt | input | 1 | Pause the receive side |
| tx_data | output | 128 | Completion beat |
| tx_valid | output | 1 | Completion beat valid |
| tx_last | output | 1 | Last beat of the completion |
| tx_ready | input | 1 | Downstream accepts the completion beat |
| credit_ret | input | 1 | One transmit credit returned |

## Verification
The main write-then-read path is run over a table of requests. The table covers both physical functions, the lowest and highest virtual function, and offsets that start both lane-aligned and unaligned. Lengths range from 1 to the full 16-dword region. This separates a wrong region index from a wrong lane order and from a wrong partial-beat zero fill. Directed cases send zero-length, misaligned and over-range requests. A dropped write is followed by a read of the same dwords, which shows that nothing was stored. Halt, transmit stall and an exhausted credit pool are each applied on their own, so that stalls on the receive side can be told apart from stalls on the transmit side.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int DW     = 32;
  localparam int LANES  = 4;
  localparam int BEAT_W = DW * LANES;

  typedef struct packed {
    logic        is_wr;
    logic [9:0]  len;
    logic [15:0] req_id;
    logic [7:0]  tag;
    logic [15:0] fid;
    logic [29:0] off;
    logic [6:0]  lo_addr;
    logic        ok;
  } req_t;

  // region index of a function: physical functions laid out in groups of nvf+1
  function automatic logic [15:0] fn_id(input int unsigned pf, input logic vfa,
                                        input int unsigned vf, input int unsigned nvf);
    int unsigned sub;
    sub = vfa ? vf + 32'd1 : 32'd0;
    return 16'(pf * (nvf + 32'd1) + sub);
  endfunction

  // data beats needed for a payload of len dwords
  function automatic logic [9:0] beats_for(input logic [9:0] len);
    logic [11:0] t;
    t = {2'b00, len} + 12'd3;
    return t[11:2];
  endfunction

  function automatic logic [BEAT_W-1:0] cpl_header(input req_t r);
    return {32'h0,
            {r.req_id, r.tag, 1'b0, r.lo_addr},
            {r.fid, 4'b0000, r.len, 2'b00},
            {8'h4A, 14'b0, r.len}};
  endfunction
endpackage

// File: rtl/mtr_hdr_decode.sv
module mtr_hdr_decode import mtr_pkg::*; #(
  parameter int NUM_PF    = 2,
  parameter int NUM_VF    = 32,
  parameter int REGION_DW = 16
) (
  input  logic [BEAT_W-1:0] beat,
  output req_t              req
);
  localparam int PF_W = (NUM_PF > 1) ? $clog2(NUM_PF) : 1;
  localparam int VF_W = (NUM_VF > 1) ? $clog2(NUM_VF) : 1;

  logic [DW-1:0]   d0, d1, d2, d3;
  logic [PF_W-1:0] pf;
  logic [VF_W-1:0] vf;
  logic            vfa, id_ok, range_ok;

  always_comb begin
    d0  = beat[0*DW +: DW];
    d1  = beat[1*DW +: DW];
    d2  = beat[2*DW +: DW];
    d3  = beat[3*DW +: DW];
    pf  = d2[PF_W-1:0];
    vfa = d2[8];
    vf  = d2[16 +: VF_W];
    req.is_wr   = d0[30];
    req.len     = d0[9:0];
    req.req_id  = d1[31:16];
    req.tag     = d1[7:0];
    req.fid     = fn_id(32'(pf), vfa, 32'(vf), 32'(NUM_VF));
    req.off     = d3[31:2];
    req.lo_addr = d3[6:0];
    id_ok    = (32'(pf) < 32'(NUM_PF)) && (!vfa || (32'(vf) < 32'(NUM_VF)));
    range_ok = ({3'b000, d3[31:2]} + {23'b0, d0[9:0]}) <= 33'(REGION_DW);
    req.ok   = (d0[9:0] != 10'd0) && (d3[1:0] == 2'b00) && id_ok && range_ok;
  end
endmodule

// File: rtl/mtr_region_ram.sv
module mtr_region_ram import mtr_pkg::*; #(
  parameter int DEPTH = 1056,
  parameter int AW    = 11
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           we,
  input  logic [LANES-1:0][AW-1:0]   waddr,
  input  logic [LANES-1:0][DW-1:0]   wdata,
  input  logic [LANES-1:0][AW-1:0]   raddr,
  output logic [LANES-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (we[i]) mem[waddr[i]] <= wdata[i];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/mtr_credit.sv
module mtr_credit #(
  parameter int INIT = 4,
  parameter int MAXV = 15,
  parameter int W    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         give,
  output logic [W-1:0] cnt,
  output logic         avail
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= W'(INIT);
    else if (give && !take && cnt < W'(MAXV))  cnt <= cnt + W'(1);
    else if (take && !give)                    cnt <= cnt - W'(1);
  end
  assign avail = (cnt != '0);
endmodule

// File: rtl/mem_tlp_target.sv
module mem_tlp_target import mtr_pkg::*; #(
  parameter int NUM_PF      = 2,
  parameter int NUM_VF      = 32,
  parameter int REGION_DW   = 16,
  parameter int CREDIT_INIT = 4,
  parameter int CREDIT_MAX  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  output logic              rx_ready,
  input  logic              rx_halt,
  output logic [BEAT_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              credit_ret
);
  localparam int NUM_FN    = NUM_PF * (NUM_VF + 1);
  localparam int RAM_DEPTH = NUM_FN * REGION_DW;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);
  localparam int CRED_W    = $clog2(CREDIT_MAX + 1);

  typedef enum logic [1:0] {ST_HDR, ST_BODY, ST_CPL} st_t;

  st_t         st;
  req_t        req_d, req_q;
  logic [9:0]  wcnt, bcnt, nbeats, rd_beat;
  logic [31:0] base;
  logic [LANES-1:0][31:0]       widx, ridx;
  logic [LANES-1:0]             lane_we, rd_in;
  logic [LANES-1:0][RAM_AW-1:0] lane_waddr, lane_raddr;
  logic [LANES-1:0][DW-1:0]     lane_wdata, lane_rdata;
  logic [BEAT_W-1:0]            dbeat;
  logic [CRED_W-1:0]            cred_cnt;
  logic                         cred_avail;

  // named events for the checker
  logic rx_fire, hdr_fire, hdr_drop, body_wr, busy, tx_fire, cpl_start, wr_any;

  mtr_hdr_decode #(.NUM_PF(NUM_PF), .NUM_VF(NUM_VF), .REGION_DW(REGION_DW)) u_dec (
    .beat(rx_data), .req(req_d));

  assign busy      = (st == ST_CPL);
  assign rx_ready  = !rx_halt && !busy;
  assign rx_fire   = rx_valid && rx_ready;
  assign hdr_fire  = rx_fire && (st == ST_HDR);
  assign hdr_drop  = hdr_fire && !req_d.ok;
  assign body_wr   = rx_fire && (st == ST_BODY) && req_q.is_wr && req_q.ok;
  assign nbeats    = beats_for(req_q.len);
  assign rd_beat   = bcnt - 10'd1;
  assign tx_valid  = busy && ((bcnt != 10'd0) || cred_avail);
  assign tx_last   = busy && (bcnt == nbeats);
  assign tx_fire   = tx_valid && tx_ready;
  assign cpl_start = tx_fire && (bcnt == 10'd0);
  assign wr_any    = |lane_we;

  always_comb begin
    base = 32'(req_q.fid) * 32'(REGION_DW) + 32'(req_q.off);
    for (int i = 0; i < LANES; i++) begin
      widx[i]       = 32'(wcnt) + 32'(i);
      lane_we[i]    = body_wr && (widx[i] < 32'(req_q.len));
      lane_waddr[i] = RAM_AW'(base + widx[i]);
      lane_wdata[i] = rx_data[i*DW +: DW];
      ridx[i]       = 32'(rd_beat) * 32'(LANES) + 32'(i);
      rd_in[i]      = (bcnt != 10'd0) && (ridx[i] < 32'(req_q.len));
      lane_raddr[i] = rd_in[i] ? RAM_AW'(base + ridx[i]) : '0;
      dbeat[i*DW +: DW] = rd_in[i] ? lane_rdata[i] : '0;
    end
    tx_data = (bcnt == 10'd0) ? cpl_header(req_q) : dbeat;
  end

  mtr_region_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(lane_we), .waddr(lane_waddr), .wdata(lane_wdata),
    .raddr(lane_raddr), .rdata(lane_rdata));

  mtr_credit #(.INIT(CREDIT_INIT), .MAXV(CREDIT_MAX), .W(CRED_W)) u_cred (
    .clk(clk), .rst_n(rst_n), .take(cpl_start), .give(credit_ret),
    .cnt(cred_cnt), .avail(cred_avail));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_HDR;
      req_q <= '0;
      wcnt  <= '0;
      bcnt  <= '0;
    end else begin
      unique case (st)
        ST_HDR: if (hdr_fire) begin
          req_q <= req_d;
          wcnt  <= '0;
          bcnt  <= '0;
          if (!rx_last)                     st <= ST_BODY;
          else if (!req_d.is_wr && req_d.ok) st <= ST_CPL;
        end
        ST_BODY: if (rx_fire) begin
          wcnt <= wcnt + 10'(LANES);
          if (rx_last) st <= (!req_q.is_wr && req_q.ok) ? ST_CPL : ST_HDR;
        end
        ST_CPL: if (tx_fire) begin
          if (tx_last) st <= ST_HDR;
          else         bcnt <= bcnt + 10'd1;
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ready,
  input logic          rx_halt,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [127:0]  tx_data,
  input logic          tx_last,
  input logic          busy,
  input logic          cpl_start,
  input logic          credit_ret,
  input logic [CW-1:0] cred_cnt,
  input logic          hdr_drop,
  input logic          wr_any
);
  // R7
  halt_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_halt |-> !rx_ready);

  // R6
  busy_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_ready);

  // R8
  credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_start |-> (cred_cnt != '0));

  // R8
  credit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_start && !credit_ret) |=> (cred_cnt == $past(cred_cnt) - CW'(1)));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R5
  drop_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_drop |=> (!busy && !wr_any));
endmodule

bind mem_tlp_target mtr_checker #(.CW(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_halt(rx_halt),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .busy(busy), .cpl_start(cpl_start), .credit_ret(credit_ret), .cred_cnt(cred_cnt),
  .hdr_drop(hdr_drop), .wr_any(wr_any));

// File: tb/tb_mem_tlp_target.sv
module tb_mem_tlp_target;
  logic         clk = 0, rst_n = 0;
  logic [127:0] rx_data = '0, tx_data;
  logic         rx_valid = 0, rx_last = 0, rx_ready, rx_halt = 0;
  logic         tx_valid, tx_last, tx_ready = 1, credit_ret = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0]  model [66][16];
  logic [127:0] cb [16];
  logic         cl [16];

  mem_tlp_target dut (.*);

  always #5 clk = ~clk;

  // {pf, vf_flag, vf, dword offset, length}
  typedef struct packed { logic [0:0] pf; logic vfa; logic [4:0] vf; logic [4:0] off; logic [9:0] len; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'd0, 1'b0, 5'd0,  5'd0,  10'd4},
    '{1'd1, 1'b0, 5'd0,  5'd3,  10'd5},
    '{1'd0, 1'b1, 5'd0,  5'd0,  10'd1},
    '{1'd0, 1'b1, 5'd31, 5'd12, 10'd4},
    '{1'd1, 1'b1, 5'd7,  5'd2,  10'd9},
    '{1'd1, 1'b1, 5'd31, 5'd0,  10'd16},
    '{1'd0, 1'b0, 5'd0,  5'd8,  10'd7},
    '{1'd1, 1'b1, 5'd0,  5'd15, 10'd1}};

  function automatic int fidx(int pf, int vfa, int vf);
    return pf * 33 + ((vfa != 0) ? vf + 1 : 0);
  endfunction

  function automatic logic [31:0] pat(int f, int o, int seed);
    return {8'(seed), 8'(f), 8'h5C, 8'(o)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_beat(input logic [127:0] d, input logic last);
    rx_data = d; rx_last = last; rx_valid = 1;
    forever begin
      #1;
      if (rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic send(input bit wr, input int pf, input int vfa, input int vf,
                      input logic [31:0] addr, input int len, input int nbody, input int seed);
    logic [127:0] h, b;
    int f, off;
    bit good;
    f = fidx(pf, vfa, vf); off = int'(addr >> 2);
    good = (len != 0) && (addr[1:0] == 2'b00) && (off + len <= 16);
    h = {addr, {11'b0, 5'(vf), 7'b0, 1'(vfa), 7'b0, 1'(pf)},
         {16'hBEEF ^ 16'(seed), 8'h0, 8'(seed)}, {1'b0, wr, 20'b0, 10'(len)}};
    put_beat(h, nbody == 0);
    for (int k = 0; k < nbody; k++) begin
      for (int j = 0; j < 4; j++) b[j*32 +: 32] = pat(f, off + k*4 + j, seed);
      put_beat(b, k == nbody - 1);
    end
    if (wr && good)
      for (int k = 0; k < len; k++) model[f][off + k] = pat(f, off + k, seed);
  endtask

  task automatic get_cpl(input int tmo, output int n);
    int w;
    w = 0; n = 0;
    while (!tx_valid && w < tmo) begin @(negedge clk); w++; end
    if (!tx_valid) return;
    forever begin
      cb[n] = tx_data; cl[n] = tx_last; n++;
      @(negedge clk);
      if (cl[n-1] || n >= 16) break;
    end
  endtask

  task automatic give_credit();
    credit_ret = 1; @(negedge clk); credit_ret = 0;
  endtask

  task automatic check_cpl(input int n, input int pf, input int vfa, input int vf,
                           input logic [31:0] addr, input int len, input int seed, input string tag);
    int f, off, nb;
    logic [127:0] eh, ed;
    f = fidx(pf, vfa, vf); off = int'(addr >> 2); nb = (len + 3) / 4;
    eh = {32'h0, {16'hBEEF ^ 16'(seed), 8'(seed), 1'b0, addr[6:0]},
          {16'(f), 4'b0, 10'(len), 2'b00}, {8'h4A, 14'b0, 10'(len)}};
    chk(n == nb + 1, {tag, " R2 beat count"}, 128'(n), 128'(nb + 1));
    if (n < 1) return;
    chk(cb[0] === eh, {tag, " R3 R4 header"}, cb[0], eh);
    for (int b = 1; b < n && b <= nb; b++) begin
      for (int j = 0; j < 4; j++)
        ed[j*32 +: 32] = ((b-1)*4 + j < len) ? model[f][off + (b-1)*4 + j] : 32'h0;
      chk(cb[b] === ed && cl[b] == (b == nb), {tag, " R1 R2 data beat"}, cb[b], ed);
    end
  endtask

  task automatic expect_none(input string tag);
    int n;
    get_cpl(30, n);
    chk(n == 0, {tag, " R5 no completion"}, 128'(n), 128'(0));
    chk(rx_ready == 1, {tag, " R5 drained, ready again"}, 128'(rx_ready), 128'(1));
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    for (int a = 0; a < 66; a++) for (int b = 0; b < 16; b++) model[a][b] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rx_ready == 1 && tx_valid == 0, "R10 reset outputs", 128'({rx_ready, tx_valid}), 128'(2'b10));
    rst_n = 1;
    @(negedge clk);
    chk(rx_ready == 1 && tx_valid == 0, "R10 after reset", 128'({rx_ready, tx_valid}), 128'(2'b10));

    // table walk: write then read back
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      send(1, v.pf, v.vfa, v.vf, {25'b0, v.off, 2'b00}, int'(v.len), (int'(v.len) + 3) / 4, i + 1);
      send(0, v.pf, v.vfa, v.vf, {25'b0, v.off, 2'b00}, int'(v.len), 0, i + 1);
      get_cpl(50, n);
      check_cpl(n, v.pf, v.vfa, v.vf, {25'b0, v.off, 2'b00}, int'(v.len), i + 1, "table");
      give_credit();
    end

    // R4 isolation: PF0 base region vs its first VF, same offset
    send(1, 0, 0, 0, 32'h0, 2, 1, 40);
    send(1, 0, 1, 0, 32'h0, 2, 1, 41);
    send(0, 0, 0, 0, 32'h0, 2, 0, 40);
    get_cpl(50, n); check_cpl(n, 0, 0, 0, 32'h0, 2, 40, "R4 pf0"); give_credit();
    send(0, 0, 1, 0, 32'h0, 2, 0, 41);
    get_cpl(50, n); check_cpl(n, 0, 1, 0, 32'h0, 2, 41, "R4 vf0"); give_credit();

    // R5 drops
    send(0, 1, 1, 31, 32'h0, 0, 0, 50);      expect_none("len0 read");
    send(0, 1, 1, 31, 32'h38, 4, 0, 51);     expect_none("over-range read");
    send(0, 1, 1, 31, 32'h5, 2, 0, 52);      expect_none("misaligned read");
    send(1, 1, 1, 31, 32'h38, 4, 1, 53);     expect_none("over-range write");
    send(1, 1, 1, 31, 32'h0, 0, 1, 54);      expect_none("len0 write");
    send(0, 1, 1, 31, 32'h30, 4, 0, 6);
    get_cpl(50, n); check_cpl(n, 1, 1, 31, 32'h30, 4, 6, "R5 region untouched"); give_credit();

    // R7 halt
    rx_halt = 1;
    fork
      send(0, 0, 0, 0, 32'h0, 4, 0, 1);
      begin
        repeat (4) @(negedge clk);
        chk(rx_ready == 0 && rx_valid == 1, "R7 halted", 128'(rx_ready), 128'(0));
        rx_halt = 0;
      end
    join
    get_cpl(50, n); check_cpl(n, 0, 0, 0, 32'h0, 4, 1, "R7 after halt"); give_credit();

    // R9 and R6: stalled transmit
    tx_ready = 0;
    send(0, 1, 1, 31, 32'h0, 8, 0, 6);
    begin
      logic [127:0] first;
      int w;
      w = 0;
      while (!tx_valid && w < 20) begin @(negedge clk); w++; end
      first = tx_data;
      repeat (3) @(negedge clk);
      chk(tx_valid == 1 && tx_data === first, "R9 hold under stall", tx_data, first);
      chk(rx_ready == 0, "R6 busy blocks receive", 128'(rx_ready), 128'(0));
    end
    tx_ready = 1;
    get_cpl(50, n); check_cpl(n, 1, 1, 31, 32'h0, 8, 6, "R9 after stall"); give_credit();

    // R8 credit exhaustion: 4 credits in hand
    for (int k = 0; k < 4; k++) begin
      send(0, 0, 1, 0, 32'h0, 2, 0, 41);
      get_cpl(50, n); check_cpl(n, 0, 1, 0, 32'h0, 2, 41, "R8 spend");
    end
    send(0, 0, 1, 0, 32'h0, 2, 0, 41);
    repeat (20) @(negedge clk);
    chk(tx_valid == 0, "R8 no credit no completion", 128'(tx_valid), 128'(0));
    chk(rx_ready == 0, "R6 waiting read holds receive", 128'(rx_ready), 128'(0));
    give_credit();
    get_cpl(50, n); check_cpl(n, 0, 1, 0, 32'h0, 2, 41, "R8 after return");
    repeat (4) give_credit();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule